// File: doc/BRIEF.md
# Receive Bit De-stuffing Decoder

This block sits on the receive side of a serial bit-oriented link. It takes recovered NRZ bits, one for each clock cycle in which `bit_en` is high, and removes the transparency bits that the transmitter added. A zero that follows a run of five ones is always dropped. When the link runs in bus configuration and one-deletion is switched on, a one that follows a run of seven zeros is dropped as well. This second rule exists so that a clock-recovery loop sees an edge at least every eight bit times on an NRZ line.

The decoder also recognises the frame delimiter and the abort sequence. A delimiter is six ones closed by a zero. It is signalled on `flag_seen`. The six ones and the zero just before them never reach the data output. A run of seven or more ones is an abort. It is signalled on `abort_seen`, and the decoder then discards all input until the next delimiter. Restored bits leave through `out_valid` / `out_bit` in their original order. They are held back by seven accepted bits, so that a delimiter or an abort can still cancel the bits that belong to it.

With one-deletion active, a zero arriving where an inserted one was due is a line error. It is reported on `line_err`, and the bit is still kept as data. Byte assembly, address matching, CRC checking and clock recovery belong to other blocks.

Top module: `rx_destuff_decoder`

## Requirements
- R1: While reset is applied and at its release, `hunting` is 1 and `out_valid`, `flag_seen`, `abort_seen` and `line_err` are 0.
- R2: `rx_bit` is sampled only in cycles with `bit_en` high. Every output pulse lasts one cycle and appears in the cycle right after the `bit_en` cycle that caused it. A cycle without `bit_en` produces no pulse.
- R3: A zero received right after exactly five consecutive ones is discarded, and both run counters restart at zero.
- R4: When `bus_mode` and `one_del_en` are both 1, a one received right after seven consecutive zeros is discarded, and both run counters restart at zero.
- R5: If `bus_mode` or `one_del_en` is 0, no one is ever discarded for a zero run, and `line_err` stays 0.
- R6: Six consecutive ones followed by a zero pulse `flag_seen` and clear `hunting`. Those six ones, that zero and the bit received just before the ones are not output.
- R7: A seventh consecutive one pulses `abort_seen` once per run, sets `hunting`, and discards every bit still held back. Further ones of the same run give no further pulse.
- R8: With one-deletion active, a zero received right after seven consecutive zeros pulses `line_err`. That zero is kept as data and starts a new zero run of length one.
- R9: Every bit that is not discarded is output exactly once and in order. A bit appears on `out_bit` with `out_valid` high in the cycle after the seventh later bit is accepted into the hold-back line.
- R10: While `hunting` is 1, no data bit is accepted, so nothing new reaches the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Qualifies `rx_bit` for this cycle |
| rx_bit | input | 1 | Recovered serial bit |
| bus_mode | input | 1 | Link runs in bus configuration (NRZ) |
| one_del_en | input | 1 | Enables deletion of the one after seven zeros (effective only with `bus_mode`) |
| out_valid | output | 1 | One-cycle strobe for a restored data bit |
| out_bit | output | 1 | Restored data bit |
| flag_seen | output | 1 | One-cycle pulse: delimiter received |
| abort_seen | output | 1 | One-cycle pulse: abort run received |
| line_err | output | 1 | One-cycle pulse: missing inserted one |
| hunting | output | 1 | Decoder is waiting for a delimiter |

## Verification
The bench runs every 10-bit payload through its own stuffing encoder, once with one-deletion active and idle cycles filled with random noise on `rx_bit`, and once with bus mode off. A decoder that miscounts a run would drop or duplicate bits or raise a spurious delimiter, and one that samples without `bit_en` would take in the noise. Payloads that end in five ones or in long zero runs push the delimiter's leading zero through stuffing and one-insertion, which exposes a decoder that cancels too few or too many held-back bits. Directed cases cover the exact output cycle, a nine-one abort that must pulse only once, the eighth zero that must flag a line error, and the gating of one-deletion by each of its two enables.

// File: rtl/rxds_pkg.sv
package rxds_pkg;

    // Action decided for one accepted serial bit, handed to the hold-back line
    typedef struct packed {
        logic push;   // append a data bit
        logic pbit;   // value of that bit
        logic kill;   // drop everything held back
    } rx_act_t;

endpackage

// File: rtl/rxds_run_tracker.sv
module rxds_run_tracker
    import rxds_pkg::*;
#(
    parameter int STUFF_ONES = 5,
    parameter int ZERO_RUN   = 7
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    bit_en,
    input  logic    rx_bit,
    input  logic    del_ones,
    output rx_act_t act,
    output logic    flag_seen,
    output logic    abort_seen,
    output logic    line_err,
    output logic    hunting
);

    localparam int FLAG_ONES  = STUFF_ONES + 1;
    localparam int ABORT_ONES = STUFF_ONES + 2;
    localparam int OW         = $clog2(ABORT_ONES + 1);
    localparam int ZW         = $clog2(ZERO_RUN + 1);

    localparam logic [OW-1:0] ONES_STUFF = OW'(STUFF_ONES);
    localparam logic [OW-1:0] ONES_FLAG  = OW'(FLAG_ONES);
    localparam logic [OW-1:0] ONES_ABORT = OW'(ABORT_ONES);
    localparam logic [ZW-1:0] ZEROS_MAX  = ZW'(ZERO_RUN);

    typedef struct packed {
        logic [OW-1:0] ones;
        logic [ZW-1:0] zeros;
        logic          hunt;
        logic          flag;
        logic          abort;
        logic          lerr;
    } trk_t;

    trk_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.flag  = 1'b0;
        s_d.abort = 1'b0;
        s_d.lerr  = 1'b0;
        act       = '0;
        if (bit_en) begin
            if (rx_bit) begin
                if (del_ones && s_q.zeros == ZEROS_MAX) begin
                    // inserted one: drop, restart both runs
                    s_d.ones  = '0;
                    s_d.zeros = '0;
                end else begin
                    s_d.zeros = '0;
                    if (s_q.ones == ONES_FLAG) begin
                        s_d.ones  = ONES_ABORT;
                        s_d.hunt  = 1'b1;
                        s_d.abort = 1'b1;
                        act.kill  = 1'b1;
                    end else if (s_q.ones != ONES_ABORT) begin
                        s_d.ones = s_q.ones + 1'b1;
                        act.push = !s_q.hunt;
                        act.pbit = 1'b1;
                    end
                end
            end else begin
                s_d.ones = '0;
                if (s_q.ones == ONES_STUFF) begin
                    s_d.zeros = '0;
                end else if (s_q.ones == ONES_FLAG) begin
                    s_d.zeros = '0;
                    s_d.hunt  = 1'b0;
                    s_d.flag  = 1'b1;
                    act.kill  = 1'b1;
                end else if (s_q.ones == ONES_ABORT) begin
                    s_d.zeros = ZW'(1);
                end else begin
                    if (del_ones && s_q.zeros == ZEROS_MAX) begin
                        s_d.lerr  = 1'b1;
                        s_d.zeros = ZW'(1);
                    end else if (s_q.zeros != ZEROS_MAX) begin
                        s_d.zeros = s_q.zeros + 1'b1;
                    end
                    act.push = !s_q.hunt;
                    act.pbit = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.hunt <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign flag_seen  = s_q.flag;
    assign abort_seen = s_q.abort;
    assign line_err   = s_q.lerr;
    assign hunting    = s_q.hunt;

endmodule

// File: rtl/rxds_hold_line.sv
module rxds_hold_line
    import rxds_pkg::*;
#(
    parameter int DEPTH = 7
) (
    input  logic    clk,
    input  logic    rst_n,
    input  rx_act_t act,
    output logic    out_valid,
    output logic    out_bit
);

    typedef struct packed {
        logic [DEPTH-1:0] vld;
        logic [DEPTH-1:0] bits;
        logic             ov;
        logic             ob;
    } line_t;

    line_t l_d, l_q;

    always_comb begin
        l_d    = l_q;
        l_d.ov = 1'b0;
        l_d.ob = 1'b0;
        if (act.kill) begin
            l_d.vld = '0;
        end else if (act.push) begin
            l_d.ov   = l_q.vld[DEPTH-1];
            l_d.ob   = l_q.vld[DEPTH-1] & l_q.bits[DEPTH-1];
            l_d.vld  = {l_q.vld[DEPTH-2:0], 1'b1};
            l_d.bits = {l_q.bits[DEPTH-2:0], act.pbit};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    assign out_valid = l_q.ov;
    assign out_bit   = l_q.ob;

endmodule

// File: rtl/rx_destuff_decoder.sv
module rx_destuff_decoder
    import rxds_pkg::*;
#(
    parameter int STUFF_ONES = 5,
    parameter int ZERO_RUN   = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic rx_bit,
    input  logic bus_mode,
    input  logic one_del_en,
    output logic out_valid,
    output logic out_bit,
    output logic flag_seen,
    output logic abort_seen,
    output logic line_err,
    output logic hunting
);

    // delimiter ones plus the bit just before them
    localparam int HOLD = STUFF_ONES + 2;

    rx_act_t act;
    logic    del_ones;

    assign del_ones = bus_mode & one_del_en;

    rxds_run_tracker #(
        .STUFF_ONES(STUFF_ONES),
        .ZERO_RUN  (ZERO_RUN)
    ) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .rx_bit    (rx_bit),
        .del_ones  (del_ones),
        .act       (act),
        .flag_seen (flag_seen),
        .abort_seen(abort_seen),
        .line_err  (line_err),
        .hunting   (hunting)
    );

    rxds_hold_line #(
        .DEPTH(HOLD)
    ) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .out_valid(out_valid),
        .out_bit  (out_bit)
    );

endmodule

// File: rtl/rxds_checker.sv
module rxds_checker (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic bus_mode,
    input logic one_del_en,
    input logic out_valid,
    input logic flag_seen,
    input logic abort_seen,
    input logic line_err,
    input logic hunting
);

    logic up_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up_q <= 1'b0;
        end else begin
            up_q <= 1'b1;
            if (!up_q) begin
                a_r1_reset_state: assert (hunting && !out_valid && !flag_seen && !abort_seen && !line_err)
                    else $error("R1 outputs wrong at reset release");
            end
        end
    end

    a_r2_no_pulse_without_en: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> !(out_valid || flag_seen || abort_seen || line_err));

    a_r5_no_lerr_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_mode && one_del_en) |=> !line_err);

    a_r6_flag_leaves_hunt: assert property (@(posedge clk) disable iff (!rst_n)
        flag_seen |-> !hunting);

    a_r7_abort_enters_hunt: assert property (@(posedge clk) disable iff (!rst_n)
        abort_seen |-> hunting);

    a_r10_quiet_in_hunt: assert property (@(posedge clk) disable iff (!rst_n)
        hunting |-> !out_valid);

    a_r2_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flag_seen, abort_seen, line_err}));

endmodule

bind rx_destuff_decoder rxds_checker u_chk (.*);

// File: tb/rx_destuff_decoder_test.sv
module rx_destuff_decoder_test;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0;
    logic rx_bit = 1'b0;
    logic bus_mode = 1'b1;
    logic one_del_en = 1'b1;
    logic out_valid, out_bit, flag_seen, abort_seen, line_err, hunting;

    int checks = 0;
    int fails = 0;
    int n_flag = 0;
    int n_abort = 0;
    int n_lerr = 0;
    bit got[$];
    bit gap = 1'b0;
    bit del_on = 1'b1;
    int tx_ones = 0;
    int tx_zeros = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_destuff_decoder uut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
        .bus_mode(bus_mode), .one_del_en(one_del_en),
        .out_valid(out_valid), .out_bit(out_bit), .flag_seen(flag_seen),
        .abort_seen(abort_seen), .line_err(line_err), .hunting(hunting)
    );

    // monitor: sample just after each rising edge
    always begin
        @(posedge clk);
        #1;
        if (rst_n) begin
            if (out_valid) got.push_back(out_bit);
            if (flag_seen) n_flag++;
            if (abort_seen) n_abort++;
            if (line_err) n_lerr++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send_bit(input bit b);
        @(negedge clk);
        bit_en = 1'b1;
        rx_bit = b;
        if (gap) begin
            @(negedge clk);
            bit_en = 1'b0;
            rx_bit = 1'($urandom);
        end
    endtask

    task automatic settle();
        @(negedge clk);
        bit_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_raw_flag();
        send_bit(1'b0);
        for (int i = 0; i < 6; i++) send_bit(1'b1);
        send_bit(1'b0);
        tx_ones = 0;
        tx_zeros = 0;
    endtask

    // bench-side transmitter: stuffing and optional one-insertion
    task automatic tx_data(input bit b);
        send_bit(b);
        if (b) begin
            tx_ones++;
            tx_zeros = 0;
            if (tx_ones == 5) begin
                send_bit(1'b0);
                tx_ones = 0;
            end
        end else begin
            tx_zeros++;
            tx_ones = 0;
            if (del_on && tx_zeros == 7) begin
                send_bit(1'b1);
                tx_zeros = 0;
            end
        end
    endtask

    task automatic tx_flag();
        tx_data(1'b0);
        for (int i = 0; i < 6; i++) send_bit(1'b1);
        send_bit(1'b0);
        tx_ones = 0;
        tx_zeros = 0;
    endtask

    function automatic int got_word();
        int w = 0;
        foreach (got[i]) w |= int'(got[i]) << i;
        return w;
    endfunction

    task automatic sweep(input string tag);
        tx_flag();
        settle();
        got.delete();
        for (int p = 0; p < 1024; p++) begin
            int nf;
            nf = n_flag;
            for (int i = 0; i < 10; i++) tx_data(p[i]);
            tx_flag();
            settle();
            chk(got.size() == 10 && got_word() == p, tag, got_word(), p);
            chk(n_flag == nf + 1 && !hunting, {tag, " flag"}, n_flag - nf, 1);
            got.delete();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int na, nl;
        repeat (3) @(negedge clk);
        chk(hunting && !out_valid && !flag_seen && !abort_seen && !line_err, "R1 during reset", hunting, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(hunting && !out_valid, "R1 after release", hunting, 1);

        // R10: data while hunting is not output
        for (int i = 0; i < 20; i++) send_bit(1'(i % 3 == 0));
        settle();
        chk(got.size() == 0 && hunting, "R10 no output in hunt", got.size(), 0);

        // R6: delimiter ends hunting
        got.delete();
        send_raw_flag();
        settle();
        chk(n_flag == 1 && !hunting, "R6 flag from hunt", n_flag, 1);

        // R9/R2: seven bits held back, eighth pushes out the first, next cycle quiet
        begin
            bit pat[8] = '{1, 0, 1, 1, 0, 0, 1, 0};
            int w = 0;
            for (int i = 0; i < 7; i++) send_bit(pat[i]);
            settle();
            chk(got.size() == 0, "R9 held back seven", got.size(), 0);
            @(negedge clk);
            bit_en = 1'b1;
            rx_bit = pat[7];
            @(negedge clk);
            bit_en = 1'b0;
            chk(out_valid && out_bit, "R2 output cycle after bit_en", out_valid, 1);
            @(negedge clk);
            chk(!out_valid, "R2 single cycle strobe", out_valid, 0);
            send_raw_flag();
            settle();
            foreach (pat[i]) w |= int'(pat[i]) << i;
            chk(got.size() == 8 && got_word() == w, "R9 order kept", got_word(), w);
            chk(n_flag == 2, "R6 closing flag", n_flag, 2);
        end

        // R3: zero after five ones dropped
        got.delete();
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b1);
        send_raw_flag();
        settle();
        chk(got.size() == 6 && got_word() == 63, "R3 stuffed zero removed", got_word(), 63);

        // R4: one after seven zeros dropped
        got.delete();
        nl = n_lerr;
        for (int i = 0; i < 7; i++) send_bit(1'b0);
        send_bit(1'b1);
        send_bit(1'b0);
        send_raw_flag();
        settle();
        chk(got.size() == 8 && got_word() == 0, "R4 inserted one removed", got.size(), 8);
        chk(n_lerr == nl, "R4 no line error", n_lerr - nl, 0);

        // R8: eighth zero is a line error and stays data
        got.delete();
        for (int i = 0; i < 8; i++) send_bit(1'b0);
        send_raw_flag();
        settle();
        chk(n_lerr == nl + 1, "R8 line error pulse", n_lerr - nl, 1);
        chk(got.size() == 8 && got_word() == 0, "R8 zero kept", got.size(), 8);

        // R5: each enable alone leaves the one in place
        for (int m = 0; m < 2; m++) begin
            bus_mode = 1'(m);
            one_del_en = 1'(1 - m);
            got.delete();
            nl = n_lerr;
            for (int i = 0; i < 7; i++) send_bit(1'b0);
            send_bit(1'b1);
            for (int i = 0; i < 8; i++) send_bit(1'b0);
            send_raw_flag();
            settle();
            chk(got.size() == 16 && got_word() == 128, "R5 one kept when disabled", got_word(), 128);
            chk(n_lerr == nl, "R5 no line error when disabled", n_lerr - nl, 0);
        end
        bus_mode = 1'b1;
        one_del_en = 1'b1;

        // R7: nine ones give one abort and enter hunting
        got.delete();
        na = n_abort;
        send_bit(1'b1);
        send_bit(1'b0);
        for (int i = 0; i < 9; i++) send_bit(1'b1);
        settle();
        chk(n_abort == na + 1, "R7 single abort pulse", n_abort - na, 1);
        chk(hunting, "R7 hunting after abort", hunting, 1);
        chk(got.size() == 1 && got[0] == 1'b1, "R7 held bits discarded", got.size(), 1);
        got.delete();
        send_bit(1'b0);
        send_bit(1'b1);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(1'b1);
        settle();
        chk(got.size() == 0 && hunting, "R10 quiet until flag", got.size(), 0);
        send_raw_flag();
        settle();
        chk(!hunting, "R6 flag ends abort hunt", hunting, 0);

        // sweeps: all 10-bit payloads (R3 R4 R9, R2 with noisy idle cycles)
        gap = 1'b1;
        del_on = 1'b1;
        sweep("R9 sweep one-deletion on");
        gap = 1'b0;
        del_on = 1'b0;
        bus_mode = 1'b0;
        sweep("R5 sweep bus mode off");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule